// File: doc/BRIEF.md
# Configurable SDRAM Command Sequencer

This block sequences commands for one bank of synchronous DRAM. A client asks for a read or write burst through a request/grant pair, and a separate refresh-request line asks for an auto-refresh. The sequencer drives one strobe per command (row activate, read, write, burst stop, precharge, auto-refresh, mode-register load) and an output enable for the write data bus. Each access opens the row, runs a burst of `BURST_LEN` beats, stops the burst, and closes the row, so the bank is always precharged when the sequencer is idle.

A 32-bit configuration register holds one-bit selectors for the memory timings: row precharge time, refresh cycle time, read and write burst-stop behaviour, an extra clock of row-open time, and a re-initialisation toggle. A register write is applied at the next idle cycle. A change of the toggle bit in either direction schedules a full initialisation sequence. That sequence runs when the next refresh request arrives, and it takes the place of that refresh.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the sequencer issues precharge, then auto-refresh tRP clocks later, a second auto-refresh tRFC clocks after that, and a mode-register load tRFC clocks after the second refresh. The first grant comes T_MRD+1 clocks after the mode-register load. The reset timings are tRP=3 and tRFC=10.
- R2: For a read, the read strobe comes 3 clocks after activate and burst stop comes BURST_LEN clocks after the read. Precharge follows burst stop by the read release latency: 3 clocks when config bit 19 is 1, 2 clocks when it is 0.
- R3: For a write, the write strobe comes 3 clocks after activate and the data output enable is high for exactly BURST_LEN clocks starting at the write strobe. When config bit 18 is 1, burst stop coincides with the last data beat and precharge follows 1 clock later. When bit 18 is 0, burst stop comes 1 clock after the last beat and precharge 1 clock after burst stop.
- R4: When config bit 25 is 1, precharge of every read or write access is delayed by one clock. Refresh timing is the same for both values of bit 25.
- R5: A waiting request is activated tRP+1 clocks after a precharge. tRP is 3 when config bit 22 is 1 and 2 when it is 0.
- R6: A waiting request is activated tRFC+1 clocks after an auto-refresh. tRFC is 10 when config bit 21 is 1 and 9 when it is 0.
- R7: The activate-to-read/write delay is 3 clocks whatever the value of config bit 20.
- R8: A refresh request and a client request pending in the same idle cycle are served refresh first. A refresh requested during an access is issued tRP+1 clocks after that access's precharge.
- R9: Each change of config bit 24 (0 to 1 or 1 to 0) arms a re-initialisation. No command results until a refresh request arrives. The refresh request then starts the R1 sequence using the current tRP and tRFC, with no separate refresh before it. A refresh with nothing armed issues no mode-register load.
- R10: The configuration register resets to 0x0278_0000. Bits 27:26 and 23 always read 0. All other bits read back what was written.
- R11: A configuration write during an access leaves that access's timing unchanged. The new values apply from the next access.
- R12: At most one of activate, read, write, precharge, refresh and mode-register load is active in any clock. The data output enable rises only with a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration register contents |
| req_i | input | 1 | Client access request, held until granted |
| req_we_i | input | 1 | Access direction, 1 = write |
| gnt_o | output | 1 | Grant, high in the activate cycle |
| ref_req_i | input | 1 | Refresh request, held until served |
| cmd_act_o | output | 1 | Row activate strobe |
| cmd_rd_o | output | 1 | Read strobe |
| cmd_wr_o | output | 1 | Write strobe |
| cmd_bst_o | output | 1 | Burst stop strobe |
| cmd_pre_o | output | 1 | Precharge strobe |
| cmd_ref_o | output | 1 | Auto-refresh strobe |
| cmd_mrs_o | output | 1 | Mode-register load strobe |
| dq_oe_o | output | 1 | Write data bus output enable |

## Verification
The bench builds the sequencer with BURST_LEN=2 and T_MRD=2. The short burst keeps each access near a dozen clocks, which makes it practical to sweep all 32 combinations of the five active timing bits for both reads and writes. Each combination checks the strobe offsets and the activate spacing that follows. With these settings the burst-stop and precharge corners stay close to each other, and each initialisation sequence finishes within about 30 clocks. That leaves room to run the re-initialisation in both toggle directions with different tRP/tRFC pairs, together with the refresh-priority and mid-access configuration-change cases.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_CMD, S_BST, S_XTND, S_PRE, S_REF,
    S_PREA, S_REF1, S_REF2, S_MRS
  } seq_state_e;

  typedef struct packed {
    logic ras_ext;    // hold row one more clock on accesses
    logic trp3;       // precharge 3 vs 2
    logic trfc10;     // refresh 10 vs 9
    logic rlat3;      // read release 3 vs 2 after burst stop
    logic wbst_same;  // burst stop on last write beat
  } seq_timing_t;

  localparam int T_RCD = 3;

  localparam int B_RAS_EXT = 25;
  localparam int B_REINIT  = 24;
  localparam int B_TRP     = 22;
  localparam int B_TRFC    = 21;
  localparam int B_RLAT    = 19;
  localparam int B_WBST    = 18;

  localparam logic [31:0] CFG_RST       = 32'h0278_0000;
  localparam logic [31:0] CFG_RSVD_MASK = 32'h0C80_0000;
  localparam seq_timing_t TIMING_RST    = '{ras_ext: 1'b1, trp3: 1'b1, trfc10: 1'b1,
                                            rlat3: 1'b1, wbst_same: 1'b0};

endpackage

// File: rtl/sdram_seq_cfg.sv
module sdram_seq_cfg
  import sdram_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output seq_timing_t timing_o,
  output logic        reinit_req_o
);

  logic [31:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (we_i) cfg_q <= wdata_i & ~CFG_RSVD_MASK;
  end

  assign rdata_o      = cfg_q;
  assign reinit_req_o = we_i && (wdata_i[B_REINIT] != cfg_q[B_REINIT]);

  assign timing_o.ras_ext   = cfg_q[B_RAS_EXT];
  assign timing_o.trp3      = cfg_q[B_TRP];
  assign timing_o.trfc10    = cfg_q[B_TRFC];
  assign timing_o.rlat3     = cfg_q[B_RLAT];
  assign timing_o.wbst_same = cfg_q[B_WBST];

  // R10: written value minus reserved bits appears one clock later
  a_r10_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o == ($past(wdata_i) & ~CFG_RSVD_MASK)));

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_MRD     = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  seq_timing_t timing_i,
  input  logic        reinit_req_i,
  input  logic        req_i,
  input  logic        req_we_i,
  input  logic        ref_req_i,
  output logic        gnt_o,
  output logic        cmd_act_o,
  output logic        cmd_rd_o,
  output logic        cmd_wr_o,
  output logic        cmd_bst_o,
  output logic        cmd_pre_o,
  output logic        cmd_ref_o,
  output logic        cmd_mrs_o,
  output logic        dq_oe_o
);

  localparam int MAX_A = (BURST_LEN > 10) ? BURST_LEN : 10;
  localparam int MAX_D = (T_MRD > MAX_A) ? T_MRD : MAX_A;
  localparam int CNT_W = $clog2(MAX_D + 1);

  seq_state_e        st_q, nxt;
  logic [CNT_W-1:0]  cnt_q, dur;
  logic              load, ent_q;
  logic              pwr_pend_q, reinit_pend_q, op_we_q;
  seq_timing_t       cur_q, eff;
  logic [CNT_W-1:0]  trp_c, trfc_c, rlat_c;

  // settings sampled while idle; frozen for the running sequence
  assign eff    = (st_q == S_IDLE) ? timing_i : cur_q;
  assign trp_c  = eff.trp3   ? CNT_W'(3)  : CNT_W'(2);
  assign trfc_c = eff.trfc10 ? CNT_W'(10) : CNT_W'(9);
  assign rlat_c = eff.rlat3  ? CNT_W'(3)  : CNT_W'(2);

  always_comb begin
    nxt  = st_q;
    dur  = CNT_W'(1);
    load = 1'b0;
    if (st_q == S_IDLE) begin
      if (pwr_pend_q || (ref_req_i && reinit_pend_q)) begin
        nxt = S_PREA; dur = trp_c; load = 1'b1;
      end else if (ref_req_i) begin
        nxt = S_REF; dur = trfc_c; load = 1'b1;
      end else if (req_i) begin
        nxt = S_ACT; dur = CNT_W'(T_RCD); load = 1'b1;
      end
    end else if (cnt_q == '0) begin
      load = 1'b1;
      case (st_q)
        S_ACT: begin nxt = S_CMD; dur = CNT_W'(BURST_LEN); end
        S_CMD: begin
          if (!op_we_q || !eff.wbst_same) begin
            nxt = S_BST;
            dur = op_we_q ? CNT_W'(1) : rlat_c;
          end else if (eff.ras_ext) begin
            nxt = S_XTND;
          end else begin
            nxt = S_PRE; dur = trp_c;
          end
        end
        S_BST: begin
          if (eff.ras_ext) nxt = S_XTND;
          else begin nxt = S_PRE; dur = trp_c; end
        end
        S_XTND: begin nxt = S_PRE;  dur = trp_c;  end
        S_PREA: begin nxt = S_REF1; dur = trfc_c; end
        S_REF1: begin nxt = S_REF2; dur = trfc_c; end
        S_REF2: begin nxt = S_MRS;  dur = CNT_W'(T_MRD); end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= S_IDLE;
      cnt_q         <= '0;
      ent_q         <= 1'b0;
      cur_q         <= TIMING_RST;
      pwr_pend_q    <= 1'b1;
      reinit_pend_q <= 1'b0;
      op_we_q       <= 1'b0;
    end else begin
      if (load) begin
        st_q  <= nxt;
        cnt_q <= dur - CNT_W'(1);
        ent_q <= 1'b1;
      end else begin
        ent_q <= 1'b0;
        if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      end
      if (st_q == S_IDLE) cur_q <= timing_i;
      if (st_q == S_IDLE && nxt == S_PREA) pwr_pend_q <= 1'b0;
      if (reinit_req_i) reinit_pend_q <= 1'b1;
      else if (st_q == S_IDLE && nxt == S_PREA) reinit_pend_q <= 1'b0;
      if (st_q == S_IDLE && nxt == S_ACT) op_we_q <= req_we_i;
    end
  end

  assign cmd_act_o = (st_q == S_ACT) && ent_q;
  assign gnt_o     = cmd_act_o;
  assign cmd_rd_o  = (st_q == S_CMD) && ent_q && !op_we_q;
  assign cmd_wr_o  = (st_q == S_CMD) && ent_q && op_we_q;
  assign cmd_bst_o = ((st_q == S_BST) && ent_q) ||
                     ((st_q == S_CMD) && op_we_q && cur_q.wbst_same && cnt_q == '0);
  assign cmd_pre_o = (st_q == S_PRE || st_q == S_PREA) && ent_q;
  assign cmd_ref_o = (st_q == S_REF || st_q == S_REF1 || st_q == S_REF2) && ent_q;
  assign cmd_mrs_o = (st_q == S_MRS) && ent_q;
  assign dq_oe_o   = (st_q == S_CMD) && op_we_q;

  a_r12_cmd_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_pre_o, cmd_ref_o, cmd_mrs_o}));

  a_r7_rcd_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_o || cmd_wr_o) |-> $past(cmd_act_o, 3));

  a_r12_oe_with_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> cmd_wr_o);

  a_r8_ref_before_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && ref_req_i) |=> !cmd_act_o);

  a_r5_pre_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_act_o |-> (!$past(cmd_pre_o, 1) && !$past(cmd_pre_o, 2)));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_MRD     = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        req_i,
  input  logic        req_we_i,
  output logic        gnt_o,
  input  logic        ref_req_i,
  output logic        cmd_act_o,
  output logic        cmd_rd_o,
  output logic        cmd_wr_o,
  output logic        cmd_bst_o,
  output logic        cmd_pre_o,
  output logic        cmd_ref_o,
  output logic        cmd_mrs_o,
  output logic        dq_oe_o
);

  seq_timing_t timing;
  logic        reinit_req;

  sdram_seq_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .timing_o    (timing),
    .reinit_req_o(reinit_req)
  );

  sdram_seq_fsm #(
    .BURST_LEN(BURST_LEN),
    .T_MRD    (T_MRD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .timing_i    (timing),
    .reinit_req_i(reinit_req),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .ref_req_i   (ref_req_i),
    .gnt_o       (gnt_o),
    .cmd_act_o   (cmd_act_o),
    .cmd_rd_o    (cmd_rd_o),
    .cmd_wr_o    (cmd_wr_o),
    .cmd_bst_o   (cmd_bst_o),
    .cmd_pre_o   (cmd_pre_o),
    .cmd_ref_o   (cmd_ref_o),
    .cmd_mrs_o   (cmd_mrs_o),
    .dq_oe_o     (dq_oe_o)
  );

endmodule

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;

  localparam int BL   = 2;
  localparam int TMRD = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_i = 1'b0, req_we_i = 1'b0, gnt_o, ref_req_i = 1'b0;
  logic        cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_bst_o, cmd_pre_o, cmd_ref_o, cmd_mrs_o, dq_oe_o;

  int cyc = 0;
  int t_rd, t_wr, t_bst, t_pre, t_ref;
  int n_pre = 0, n_ref = 0, n_mrs = 0, n_oe = 0;
  int n_chk = 0, n_fail = 0;
  bit r24 = 1'b0;

  sdram_cmd_seq #(.BURST_LEN(BL), .T_MRD(TMRD)) dut_i (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) if (rst_ni) begin
    if (cmd_rd_o)  t_rd  = cyc;
    if (cmd_wr_o)  t_wr  = cyc;
    if (cmd_bst_o) t_bst = cyc;
    if (cmd_pre_o) begin t_pre = cyc; n_pre++; end
    if (cmd_ref_o) begin t_ref = cyc; n_ref++; end
    if (cmd_mrs_o) n_mrs++;
    if (dq_oe_o)   n_oe++;
  end

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit ext, bit trp3, bit trfc10, bit rlat3, bit wbst, bit rst24, bit rcd);
    logic [31:0] v = 32'h0001_2345;
    v[25] = ext; v[24] = rst24; v[22] = trp3; v[21] = trfc10;
    v[20] = rcd; v[19] = rlat3; v[18] = wbst;
    return v;
  endfunction

  task automatic cfg_write(logic [31:0] v);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  // two back-to-back accesses; checks the first and the gap to the second
  task automatic run_pair(bit we, logic [31:0] v);
    int t0, t1, oe0, exp_bst, exp_pre;
    int ext = v[25], trp = v[22] ? 3 : 2, rlat = v[19] ? 3 : 2;
    @(negedge clk_i); req_i = 1'b1; req_we_i = we; oe0 = n_oe;
    do @(negedge clk_i); while (!gnt_o);
    t0 = cyc;
    do @(negedge clk_i); while (!gnt_o);
    t1 = cyc; req_i = 1'b0;
    if (we) begin
      chk("R7 wr after act", t_wr - t0, 3);
      chk("R3 oe beats", n_oe - oe0, BL);
      exp_bst = v[18] ? 3 + BL - 1 : 3 + BL;
      exp_pre = 3 + BL + (v[18] ? 0 : 1) + ext;
      chk("R3 bst offset", t_bst - t0, exp_bst);
      chk("R4 R3 pre offset", t_pre - t0, exp_pre);
    end else begin
      chk("R7 rd after act", t_rd - t0, 3);
      chk("R12 no oe on read", n_oe - oe0, 0);
      chk("R2 bst offset", t_bst - t0, 3 + BL);
      chk("R4 R2 pre offset", t_pre - t0, 3 + BL + rlat + ext);
    end
    chk("R5 act after pre", t1 - t_pre, trp + 1);
    repeat (25) @(negedge clk_i);
  endtask

  task automatic run_ref(logic [31:0] v);
    int r0, m0, tg;
    cfg_write(v);
    r0 = n_ref; m0 = n_mrs;
    @(negedge clk_i); ref_req_i = 1'b1; req_i = 1'b1; req_we_i = 1'b0;
    do begin
      @(negedge clk_i);
      if (cmd_ref_o) ref_req_i = 1'b0;
    end while (!gnt_o);
    tg = cyc; req_i = 1'b0;
    chk("R8 refresh served first", n_ref - r0, 1);
    chk("R6 R4 act after ref", tg - t_ref, (v[21] ? 10 : 9) + 1);
    chk("R9 no mrs on plain refresh", n_mrs - m0, 0);
    repeat (25) @(negedge clk_i);
  endtask

  task automatic run_init_seq(string r, int trp, int trfc, bit from_reset);
    int tp = -1, r1 = -1, r2 = -1, tm = -1, tg, p0;
    p0 = n_pre;
    if (!from_reset) begin
      @(negedge clk_i); ref_req_i = 1'b1; req_i = 1'b1; req_we_i = 1'b0;
    end
    do begin
      @(negedge clk_i);
      if (cmd_pre_o) begin tp = cyc; ref_req_i = 1'b0; end
      if (cmd_ref_o) begin if (r1 < 0) r1 = cyc; else r2 = cyc; end
      if (cmd_mrs_o) tm = cyc;
    end while (!gnt_o);
    tg = cyc; req_i = 1'b0;
    chk({r, " one precharge"}, n_pre - p0, 1);
    chk({r, " ref1 after pre"}, r1 - tp, trp);
    chk({r, " ref2 after ref1"}, r2 - r1, trfc);
    chk({r, " mrs after ref2"}, tm - r2, trfc);
    chk({r, " grant after mrs"}, tg - tm, TMRD + 1);
    repeat (10) @(negedge clk_i);
  endtask

  task automatic run_reinit(string r, logic [31:0] v);
    int p0, m0;
    cfg_write(v);
    p0 = n_pre; m0 = n_mrs;
    repeat (20) @(negedge clk_i);
    chk({r, " idle without refresh pre"}, n_pre - p0, 0);
    chk({r, " idle without refresh mrs"}, n_mrs - m0, 0);
    run_init_seq(r, v[22] ? 3 : 2, v[21] ? 10 : 9, 1'b0);
  endtask

  initial begin
    int t0, t1;
    logic [31:0] v, v2;
    req_i = 1'b1; req_we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R10 reset value", cfg_rdata_o, 32'h0278_0000);
    rst_ni = 1'b1;
    run_init_seq("R1 power-on", 3, 10, 1'b1);

    cfg_write(32'hFFFF_FFFF);
    chk("R10 reserved read zero", cfg_rdata_o, 32'hF37F_FFFF);
    cfg_write(32'h0000_0000);
    chk("R10 all zero readback", cfg_rdata_o, 32'h0000_0000);
    // two toggles above leave one re-initialisation armed
    run_reinit("R9 armed", mk(1, 1, 1, 1, 0, 0, 1));

    for (int k = 0; k < 32; k++) begin
      v = mk(k[4], k[3], k[2], k[1], k[0], r24, k[2] ^ k[0]);
      cfg_write(v);
      run_pair(1'b0, v);
      run_pair(1'b1, v);
    end

    run_ref(mk(1, 1, 1, 1, 0, r24, 1));
    run_ref(mk(0, 0, 0, 0, 1, r24, 1));
    run_ref(mk(1, 0, 0, 1, 1, r24, 0));

    r24 = 1'b1;
    run_reinit("R9 rise", mk(0, 0, 0, 1, 0, r24, 1));
    r24 = 1'b0;
    run_reinit("R9 fall", mk(1, 1, 0, 0, 1, r24, 1));

    // R8: refresh during an access waits for precharge + tRP
    v = mk(0, 1, 1, 1, 0, r24, 1);
    cfg_write(v);
    @(negedge clk_i); req_i = 1'b1; req_we_i = 1'b0;
    do @(negedge clk_i); while (!gnt_o);
    req_i = 1'b0; ref_req_i = 1'b1;
    do @(negedge clk_i); while (!cmd_ref_o);
    ref_req_i = 1'b0; t0 = cyc;
    chk("R8 ref after access pre", t0 - t_pre, 3 + 1);
    repeat (20) @(negedge clk_i);

    // R11: config change during an access
    v  = mk(1, 1, 1, 1, 0, r24, 1);
    v2 = mk(0, 0, 1, 0, 0, r24, 1);
    cfg_write(v);
    @(negedge clk_i); req_i = 1'b1; req_we_i = 1'b0;
    do @(negedge clk_i); while (!gnt_o);
    t0 = cyc;
    cfg_write(v2);
    do @(negedge clk_i); while (!gnt_o);
    t1 = cyc; req_i = 1'b0;
    chk("R11 running access keeps pre", t_pre - t0, 3 + BL + 3 + 1);
    chk("R11 running access keeps trp", t1 - t_pre, 3 + 1);
    repeat (20) @(negedge clk_i);
    chk("R11 next access uses new", t_pre - t1, 3 + BL + 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule